// File: doc/BRIEF.md
# Trimmed Time-of-Day Counter for Precision Time Protocol

This block keeps a free-running time of day: a 32-bit seconds count, a 32-bit nanoseconds count that wraps at one second, and a 3-bit phase that counts 8 ns sub-periods inside each 40 ns period. The nanoseconds advance by the nominal 40 ns once per period. A fractional rate word can trim the count. It holds a 30-bit magnitude that is added into a 32-bit sub-nanosecond accumulator on every period. Each overflow of the accumulator adds one nanosecond or takes one away, according to a direction flag.

Software reaches the block through a plain synchronous register port. A control word holds persistent enables and four self-clearing commands: a soft reset of the live time, a snapshot of the live time into shadow registers, a load of the shadow registers into the live time, and a signed step that adds or subtracts the shadow seconds and nanoseconds. A small command state machine starts the commands. From idle it enters one action state for the most urgent pending command (ST_RST, ST_LOAD, ST_STEP or ST_SNAP), pulses that action for one cycle, then passes through ST_CLEAR. ST_CLEAR wipes all command bits, and the machine returns to ST_IDLE. The transitions are IDLE→action when any command bit is set, action→CLEAR always, and CLEAR→IDLE always. The live time is also driven onto output ports for timestamping logic nearby.

Top module: `ptp_trim_clock`

## Requirements
- R1: After reset, every register reads zero: control at 0x500, phase at 0x502, nanoseconds at 0x504, seconds at 0x508 and rate at 0x50C. The live seconds, nanoseconds and phase outputs are also zero.
- R2: While control bit 1 (run) is set, the phase steps 0,1,2,3,4 once per clock cycle, each step standing for 8 ns. On the cycle the phase leaves 4, the nanoseconds advance by 40.
- R3: When a nanoseconds update reaches NS_WRAP, the nanoseconds lose NS_WRAP and the seconds gain one.
- R4: Setting control bit 4 (snapshot) copies the live seconds, nanoseconds and phase into the shadow registers at 0x508, 0x504 and 0x502. Bits 2:0 of 0x502 hold the phase.
- R5: Setting control bit 3 (load) copies the shadow seconds, nanoseconds and phase into the live time.
- R6: Setting control bit 6 (step) adds the shadow seconds and nanoseconds to the live time when control bit 5 is 1, and subtracts them when bit 5 is 0. The nanoseconds borrow from or carry into the seconds.
- R7: The rate register at 0x50C keeps bit 31 as the direction flag and bits 29:0 as the magnitude. Bit 30 reads as zero. While control bit 2 (trim) is set, every 40 ns period adds the magnitude into a 32-bit accumulator. An overflow adds one extra nanosecond on that period when the direction is 1, and one fewer when it is 0.
- R8: While control bit 2 is clear, the rate register has no effect and each period advances exactly 40 ns.
- R9: Command bits 0, 3, 4 and 6 clear themselves after their command acts. Bits 1, 2 and 5 keep their written values.
- R10: When several commands are set together, only the most urgent one acts, in the order reset, load, step, snapshot. All of them are cleared.
- R11: While run is clear, the live seconds, nanoseconds and phase hold their values.
- R12: Control bit 0 (soft reset) zeroes the live time and the rate accumulator. The shadow registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle per 8 ns phase step |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| tod_sec | output | 32 | Live seconds |
| tod_ns | output | 32 | Live nanoseconds |
| tod_phase | output | 3 | Live 8 ns sub-period phase |

## Verification
The bench builds the block with NS_WRAP set to 1000 instead of one billion, keeping the other parameters at their defaults. This puts the nanoseconds-to-seconds carry, and the borrow and carry of signed steps, within a few periods of any loaded time. A full-scale rate magnitude over 20 periods gives four accumulator overflows. That makes the trimmed count 804 or 796 against a nominal 800, an exact figure for both directions. The bench frames run intervals to the cycle, so the phase seen by a snapshot is also exact.

// File: rtl/ptp_trim_pkg.sv
package ptp_trim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_LOAD,
        ST_STEP,
        ST_SNAP,
        ST_CLEAR
    } cmd_state_e;

    // control word bit positions
    localparam int unsigned CB_RST  = 0;
    localparam int unsigned CB_RUN  = 1;
    localparam int unsigned CB_TRIM = 2;
    localparam int unsigned CB_LOAD = 3;
    localparam int unsigned CB_SNAP = 4;
    localparam int unsigned CB_DIR  = 5;
    localparam int unsigned CB_STEP = 6;
    localparam int unsigned CTRL_W  = 7;

    localparam logic [CTRL_W-1:0] CMD_MASK =
        CTRL_W'((1 << CB_RST) | (1 << CB_LOAD) | (1 << CB_SNAP) | (1 << CB_STEP));

    // register offsets
    localparam logic [15:0] OFS_CTRL  = 16'h0500;
    localparam logic [15:0] OFS_PHASE = 16'h0502;
    localparam logic [15:0] OFS_NS    = 16'h0504;
    localparam logic [15:0] OFS_SEC   = 16'h0508;
    localparam logic [15:0] OFS_RATE  = 16'h050C;

    typedef struct packed {
        logic [31:0] sec;
        logic [31:0] ns;
        logic [2:0]  phase;
    } tod_t;

endpackage

// File: rtl/ptp_cmd_fsm.sv
module ptp_cmd_fsm
    import ptp_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              do_rst_o,
    output logic              do_load_o,
    output logic              do_step_o,
    output logic              do_snap_o,
    output logic              cmd_clr_o
);

    cmd_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: urgency reset > load > step > snapshot
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if      (ctrl_i[CB_RST])  state_d = ST_RST;
                else if (ctrl_i[CB_LOAD]) state_d = ST_LOAD;
                else if (ctrl_i[CB_STEP]) state_d = ST_STEP;
                else if (ctrl_i[CB_SNAP]) state_d = ST_SNAP;
            end
            ST_RST, ST_LOAD, ST_STEP, ST_SNAP: state_d = ST_CLEAR;
            ST_CLEAR:                          state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        do_rst_o  = 1'b0;
        do_load_o = 1'b0;
        do_step_o = 1'b0;
        do_snap_o = 1'b0;
        cmd_clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RST:   do_rst_o  = 1'b1;
            ST_LOAD:  do_load_o = 1'b1;
            ST_STEP:  do_step_o = 1'b1;
            ST_SNAP:  do_snap_o = 1'b1;
            ST_CLEAR: cmd_clr_o = 1'b1;
            default:  ;
        endcase
    end

    // R10: load wins over step when both are pending and reset is not
    assert_load_over_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctrl_i[CB_LOAD] && ctrl_i[CB_STEP] && !ctrl_i[CB_RST])
        |=> (do_load_o && !do_step_o));

endmodule

// File: rtl/ptp_regfile.sv
module ptp_regfile
    import ptp_trim_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int MAG_W   = 30,
    parameter int DIR_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              snap_i,
    input  tod_t              live_i,
    input  logic              cmd_clr_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output tod_t              shadow_o,
    output logic [31:0]       rate_o,
    output logic [31:0]       rdata_o
);

    localparam logic [31:0] RATE_KEEP = (32'(1) << DIR_BIT) | ((32'(1) << MAG_W) - 32'(1));

    logic [CTRL_W-1:0] ctrl_q;
    tod_t              shadow_q;
    logic [31:0]       rate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            shadow_q <= '0;
            rate_q   <= '0;
        end else begin
            if (wr_i) begin
                if (addr_i == ADDR_W'(OFS_CTRL))  ctrl_q         <= wdata_i[CTRL_W-1:0];
                if (addr_i == ADDR_W'(OFS_PHASE)) shadow_q.phase <= wdata_i[2:0];
                if (addr_i == ADDR_W'(OFS_NS))    shadow_q.ns    <= wdata_i;
                if (addr_i == ADDR_W'(OFS_SEC))   shadow_q.sec   <= wdata_i;
                if (addr_i == ADDR_W'(OFS_RATE))  rate_q         <= wdata_i & RATE_KEEP;
            end
            if (snap_i)    shadow_q <= live_i;
            if (cmd_clr_i) ctrl_q   <= ctrl_q & ~CMD_MASK;
        end
    end

    always_comb begin
        rdata_o = '0;
        if      (addr_i == ADDR_W'(OFS_CTRL))  rdata_o = 32'(ctrl_q);
        else if (addr_i == ADDR_W'(OFS_PHASE)) rdata_o = 32'(shadow_q.phase);
        else if (addr_i == ADDR_W'(OFS_NS))    rdata_o = shadow_q.ns;
        else if (addr_i == ADDR_W'(OFS_SEC))   rdata_o = shadow_q.sec;
        else if (addr_i == ADDR_W'(OFS_RATE))  rdata_o = rate_q;
    end

    assign ctrl_o   = ctrl_q;
    assign shadow_o = shadow_q;
    assign rate_o   = rate_q;

    // R9: the clear pulse leaves no command bit standing
    assert_cmd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr_i && !wr_i) |=> ((ctrl_q & CMD_MASK) == '0));

endmodule

// File: rtl/ptp_rate_trim.sv
module ptp_rate_trim #(
    parameter int FRAC_W  = 32,
    parameter int MAG_W   = 30,
    parameter int DIR_BIT = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        tick_i,
    input  logic        trim_en_i,
    input  logic [31:0] rate_i,
    output logic        adj_up_o,
    output logic        adj_dn_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;
    logic              advance;

    assign advance  = tick_i && trim_en_i;
    assign sum      = {1'b0, acc_q} + (FRAC_W+1)'(rate_i[MAG_W-1:0]);
    assign adj_up_o = advance && sum[FRAC_W] &&  rate_i[DIR_BIT];
    assign adj_dn_o = advance && sum[FRAC_W] && !rate_i[DIR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (clr_i)   acc_q <= '0;
        else if (advance) acc_q <= sum[FRAC_W-1:0];
    end

    // R8: with trim off the accumulator never moves
    assert_acc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trim_en_i && !clr_i) |=> $stable(acc_q));

endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
    import ptp_trim_pkg::*;
#(
    parameter int NS_WRAP     = 1000000000,
    parameter int NOMINAL_NS  = 40,
    parameter int PHASE_STEPS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic do_rst_i,
    input  logic do_load_i,
    input  logic do_step_i,
    input  logic step_add_i,
    input  tod_t shadow_i,
    input  logic adj_up_i,
    input  logic adj_dn_i,
    output logic tick_o,
    output tod_t live_o
);

    localparam logic [32:0] WRAP33  = 33'(NS_WRAP);
    localparam logic [32:0] NOM33   = 33'(NOMINAL_NS);
    localparam logic [2:0]  PH_LAST = 3'(PHASE_STEPS - 1);

    logic [31:0] sec_q, ns_q;
    logic [2:0]  phase_q;

    logic [31:0] sec_b, ns_b, sec_n, ns_n;
    logic [2:0]  phase_n;
    logic [32:0] sum_s, sum_t, inc;

    assign tick_o = run_i && (phase_q == PH_LAST);

    // stage 1: signed step
    always_comb begin
        sec_b = sec_q;
        ns_b  = ns_q;
        sum_s = {1'b0, ns_q} + {1'b0, shadow_i.ns};
        if (do_step_i) begin
            if (step_add_i) begin
                if (sum_s >= WRAP33) begin
                    ns_b  = 32'(sum_s - WRAP33);
                    sec_b = sec_q + shadow_i.sec + 32'd1;
                end else begin
                    ns_b  = sum_s[31:0];
                    sec_b = sec_q + shadow_i.sec;
                end
            end else begin
                if (ns_q >= shadow_i.ns) begin
                    ns_b  = ns_q - shadow_i.ns;
                    sec_b = sec_q - shadow_i.sec;
                end else begin
                    ns_b  = 32'({1'b0, ns_q} + WRAP33 - {1'b0, shadow_i.ns});
                    sec_b = sec_q - shadow_i.sec - 32'd1;
                end
            end
        end
    end

    // stage 2: period advance with trim
    always_comb begin
        inc   = NOM33 + 33'(adj_up_i) - 33'(adj_dn_i);
        sum_t = {1'b0, ns_b} + inc;
        sec_n = sec_b;
        ns_n  = ns_b;
        if (tick_o) begin
            if (sum_t >= WRAP33) begin
                ns_n  = 32'(sum_t - WRAP33);
                sec_n = sec_b + 32'd1;
            end else begin
                ns_n  = sum_t[31:0];
            end
        end
        phase_n = phase_q;
        if (run_i) phase_n = tick_o ? 3'd0 : phase_q + 3'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q   <= '0;
            ns_q    <= '0;
            phase_q <= '0;
        end else if (do_rst_i) begin
            sec_q   <= '0;
            ns_q    <= '0;
            phase_q <= '0;
        end else if (do_load_i) begin
            sec_q   <= shadow_i.sec;
            ns_q    <= shadow_i.ns;
            phase_q <= (shadow_i.phase <= PH_LAST) ? shadow_i.phase : 3'd0;
        end else begin
            sec_q   <= sec_n;
            ns_q    <= ns_n;
            phase_q <= phase_n;
        end
    end

    assign live_o = '{sec: sec_q, ns: ns_q, phase: phase_q};

    // R2: phase stays inside one period
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= PH_LAST);

    // R11: time holds while stopped and no command acts
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !do_rst_i && !do_load_i && !do_step_i)
        |=> ($stable(sec_q) && $stable(ns_q) && $stable(phase_q)));

    // R5: load lands the shadow nanoseconds and seconds
    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load_i && !do_rst_i) |=> (ns_q == $past(shadow_i.ns) && sec_q == $past(shadow_i.sec)));

endmodule

// File: rtl/ptp_trim_clock.sv
module ptp_trim_clock
    import ptp_trim_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int NS_WRAP     = 1000000000,
    parameter int NOMINAL_NS  = 40,
    parameter int PHASE_NS    = 8,
    parameter int FRAC_W      = 32,
    parameter int MAG_W       = 30,
    parameter int DIR_BIT     = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [31:0]       tod_sec,
    output logic [31:0]       tod_ns,
    output logic [2:0]        tod_phase
);

    localparam int PHASE_STEPS = NOMINAL_NS / PHASE_NS;

    logic [CTRL_W-1:0] ctrl;
    tod_t              shadow, live;
    logic [31:0]       rate;
    logic              do_rst, do_load, do_step, do_snap, cmd_clr;
    logic              tick, adj_up, adj_dn;

    ptp_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_i    (ctrl),
        .do_rst_o  (do_rst),
        .do_load_o (do_load),
        .do_step_o (do_step),
        .do_snap_o (do_snap),
        .cmd_clr_o (cmd_clr)
    );

    ptp_regfile #(.ADDR_W(ADDR_W), .MAG_W(MAG_W), .DIR_BIT(DIR_BIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .snap_i    (do_snap),
        .live_i    (live),
        .cmd_clr_i (cmd_clr),
        .ctrl_o    (ctrl),
        .shadow_o  (shadow),
        .rate_o    (rate),
        .rdata_o   (reg_rdata)
    );

    ptp_rate_trim #(.FRAC_W(FRAC_W), .MAG_W(MAG_W), .DIR_BIT(DIR_BIT)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (do_rst),
        .tick_i    (tick),
        .trim_en_i (ctrl[CB_TRIM]),
        .rate_i    (rate),
        .adj_up_o  (adj_up),
        .adj_dn_o  (adj_dn)
    );

    ptp_tod_core #(.NS_WRAP(NS_WRAP), .NOMINAL_NS(NOMINAL_NS), .PHASE_STEPS(PHASE_STEPS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl[CB_RUN]),
        .do_rst_i   (do_rst),
        .do_load_i  (do_load),
        .do_step_i  (do_step),
        .step_add_i (ctrl[CB_DIR]),
        .shadow_i   (shadow),
        .adj_up_i   (adj_up),
        .adj_dn_i   (adj_dn),
        .tick_o     (tick),
        .live_o     (live)
    );

    assign tod_sec   = live.sec;
    assign tod_ns    = live.ns;
    assign tod_phase = live.phase;

    // R12: soft reset zeroes the live time on the next edge
    assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        do_rst |=> (tod_sec == '0 && tod_ns == '0 && tod_phase == '0));

endmodule

// File: tb/tb_ptp_trim_clock.sv
module tb_ptp_trim_clock;

    localparam int WRAP = 1000;
    localparam logic [15:0] A_CTRL = 16'h0500, A_PH = 16'h0502, A_NS = 16'h0504,
                            A_SEC = 16'h0508, A_RATE = 16'h050C;
    localparam logic [31:0] B_RST = 32'h01, B_RUN = 32'h02, B_TRIM = 32'h04, B_LOAD = 32'h08,
                            B_SNAP = 32'h10, B_DIR = 32'h20, B_STEP = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, tod_sec, tod_ns;
    logic [2:0]  tod_phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptp_trim_clock #(.NS_WRAP(WRAP)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_phase(tod_phase)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%h) expected=%0d (0x%h)", req, act, act, exp, exp);
        end
    endtask

    // called at a negedge; latches on the next posedge; returns at the following negedge
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cmd(input logic [31:0] bits);
        wr(A_CTRL, bits);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_time(input logic [31:0] s, input logic [31:0] n, input logic [31:0] p);
        wr(A_PH, p); wr(A_NS, n); wr(A_SEC, s);
        cmd(B_LOAD);
    endtask

    // run exactly n clock edges with the given persistent bits
    task automatic run(input int n, input logic [31:0] extra);
        wr(A_CTRL, B_RUN | extra);
        repeat (n - 1) @(negedge clk);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic snap_chk(input string req, input logic [31:0] s, input logic [31:0] n,
                            input logic [31:0] p);
        logic [31:0] v;
        cmd(B_SNAP);
        rd(A_SEC, v); chk(req, v, s);
        rd(A_NS, v);  chk(req, v, n);
        rd(A_PH, v);  chk(req, v, p);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_PH, v);   chk("R1 phase", v, 0);
        rd(A_NS, v);   chk("R1 ns", v, 0);
        rd(A_SEC, v);  chk("R1 sec", v, 0);
        rd(A_RATE, v); chk("R1 rate", v, 0);
        chk("R1 live", {tod_sec[15:0], tod_ns[12:0], tod_phase}, 0);
    endtask

    task automatic t_nominal;
        set_time(7, 100, 0);
        chk("R5 live ns", tod_ns, 100);
        chk("R5 live sec", tod_sec, 7);
        run(10, 0);
        snap_chk("R2 two periods", 7, 180, 0);
        run(3, 0);
        snap_chk("R4 phase capture", 7, 180, 3);
        run(2, 0);
        snap_chk("R2 period close", 7, 220, 0);
    endtask

    task automatic t_wrap;
        set_time(5, 990, 0);
        run(5, 0);
        snap_chk("R3 wrap", 6, 30, 0);
        repeat (20) @(negedge clk);
        snap_chk("R11 hold", 6, 30, 0);
    endtask

    task automatic t_step;
        logic [31:0] v;
        set_time(10, 100, 0);
        wr(A_SEC, 3); wr(A_NS, 300);
        cmd(B_STEP);
        chk("R6 sub sec", tod_sec, 6);
        chk("R6 sub ns", tod_ns, 800);
        rd(A_CTRL, v); chk("R9 cleared", v, 0);
        wr(A_SEC, 2); wr(A_NS, 300);
        cmd(B_STEP | B_DIR);
        chk("R6 add sec", tod_sec, 9);
        chk("R6 add ns", tod_ns, 100);
        rd(A_CTRL, v); chk("R9 dir kept", v, B_DIR);
        wr(A_CTRL, 0);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        set_time(1, 1, 0);
        wr(A_SEC, 40); wr(A_NS, 400); wr(A_PH, 0);
        cmd(B_LOAD | B_STEP | B_DIR | B_SNAP);
        chk("R10 load wins sec", tod_sec, 40);
        chk("R10 load wins ns", tod_ns, 400);
        rd(A_CTRL, v); chk("R10 all cleared", v, B_DIR);
        wr(A_CTRL, 0);
    endtask

    task automatic t_rate;
        logic [31:0] v;
        wr(A_RATE, 32'hFFFF_FFFF);
        rd(A_RATE, v); chk("R7 rate fields", v, 32'hBFFF_FFFF);
        cmd(B_RST); set_time(0, 0, 0);
        run(100, B_TRIM);
        snap_chk("R7 fast", 0, 804, 0);
        wr(A_RATE, 32'h3FFF_FFFF);
        cmd(B_RST); set_time(0, 0, 0);
        run(100, B_TRIM);
        snap_chk("R7 slow", 0, 796, 0);
        cmd(B_RST); set_time(0, 0, 0);
        run(100, 0);
        snap_chk("R8 trim off", 0, 800, 0);
    endtask

    task automatic t_soft_reset;
        logic [31:0] v;
        set_time(9, 9, 0);
        run(2, 0);
        cmd(B_RST);
        chk("R12 live sec", tod_sec, 0);
        chk("R12 live ns", tod_ns, 0);
        chk("R12 live phase", 32'(tod_phase), 0);
        rd(A_NS, v);  chk("R12 shadow ns kept", v, 9);
        rd(A_SEC, v); chk("R12 shadow sec kept", v, 9);
        rd(A_CTRL, v); chk("R9 reset bit cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nominal();
        t_wrap();
        t_step();
        t_priority();
        t_rate();
        t_soft_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule